// File: doc/BRIEF.md
# Paired Byte-Port GPIO Controller with Encoded Interrupt Vectors

This block controls sixteen general-purpose pins arranged as two 8-bit ports. Port A owns pins 0 to 7 and port B owns pins 8 to 15. Software reaches both ports through a single half-word register map. Each byte lane of a register belongs to one port, so software can treat the pair as one 16-bit port or touch either 8-bit port alone. For every pin there is a direction bit, an output value, an input readback, a pull-resistor enable with an up/down select, an interrupt enable and an edge select. Pad levels pass through a two-flop synchronizer before they are read back or checked for edges.

Each selected edge sets a per-pin flag. Each port has its own encoded vector register. The vector names the lowest-numbered pin of that port whose flag and enable are both set. Reading the vector also clears that flag. The combined pair has no vector register of its own. Each port raises one interrupt request line.

The bus is simple. Register index `bus_addr` and lane enables `bus_be` qualify a write strobe `bus_we`. A read strobe `bus_re` returns registered data on the following cycle.

Top module: `gpio_pair_port`

## Requirements
- R1: Register index 2 (direction) drives `pad_oe`. A 1 in a bit makes that pin an output. All direction bits reset to 0.
- R2: Register index 1 (output data) drives `pad_out`. Register index 0 (input data) is separate and reads the pad level two clocks after the level is applied. Writes to index 0 have no effect.
- R3: Register index 3 (pull enable) drives `pad_pull_en`. Register index 4 (pull direction, 1 = up, 0 = down) drives `pad_pull_up`.
- R4: When `bus_be` is 2'b11, a write updates all 16 bits. When only `bus_be[0]` is set, only bits 7:0 (port A) change. When only `bus_be[1]` is set, only bits 15:8 (port B) change.
- R5: Register index 6 selects the edge for each pin (0 = rising, 1 = falling). The flag bit in register index 7 is set on the clock after the input register first shows the selected edge. Flags are set whether or not the pin's interrupt is enabled.
- R6: Register indices 8 (port A) and 9 (port B) return the port's vector in bits 7:0, with bits 15:8 at zero. The vector is 0 when no pin of the port has both its flag and its enable (register index 5) set. Otherwise it is 2×(n+1), where n is the lowest such pin counted within the port (0 to 7).
- R7: Reading a nonzero vector clears exactly the flag it reported. Reading a zero vector changes no flag.
- R8: Writing register index 7 loads the flag bits of the enabled lanes directly. An edge event in the same cycle still sets its flag.
- R9: `irq[p]` is high exactly when port p has at least one pin with both its flag and its enable set.
- R10: Register indices 10 to 15 read as 0, and writes to them change no state. No vector register exists for the combined 16-bit port.
- R11: `bus_rdata` carries the read result in the cycle after `bus_re` and is 0 in any cycle that follows no read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 4 | Register index |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_be | input | 2 | Byte-lane enables for writes (bit 0 = port A) |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| pad_in | input | 16 | Pad input levels |
| pad_oe | output | 16 | Per-pin output enable |
| pad_out | output | 16 | Per-pin output value |
| pad_pull_en | output | 16 | Per-pin pull enable |
| pad_pull_up | output | 16 | Per-pin pull select, 1 = up |
| irq | output | 2 | Interrupt request per port |

## Verification
The hardest case to reach from the ports is a vector read that must clear one flag while other pending flags stay set. Some of those flags belong to enabled pins and some to disabled pins. To build this case, the stimulus enables only a subset of pins and then raises several pad lines at once, including one pin that is not enabled. It then reads the vector repeatedly. Each read must step to the next enabled pin, and the last read must return zero while the flag register still shows the disabled pin as set. A reference model updated on every clock follows the flags and lane writes across the whole run. It catches any disagreement in cycles that the directed checks do not sample.

// File: rtl/gpio_pair_pkg.sv
package gpio_pair_pkg;
  localparam int PORT_PINS = 8;
  localparam int NUM_PORTS = 2;
  localparam int ADDR_W    = 4;
  localparam int VEC_W     = 8;
  localparam int NUM_REGS  = 8;

  typedef enum logic [ADDR_W-1:0] {
    RIDX_IN     = 4'd0,
    RIDX_OUT    = 4'd1,
    RIDX_DIR    = 4'd2,
    RIDX_PULLEN = 4'd3,
    RIDX_PULLUP = 4'd4,
    RIDX_IEN    = 4'd5,
    RIDX_EDGE   = 4'd6,
    RIDX_FLAG   = 4'd7,
    RIDX_VEC_A  = 4'd8,
    RIDX_VEC_B  = 4'd9
  } reg_idx_e;

  // encoded vector: 0 if none pending, else 2*(lowest pin + 1)
  function automatic logic [VEC_W-1:0] vec_code(input logic [PORT_PINS-1:0] pend);
    logic [VEC_W-1:0] code;
    code = '0;
    for (int i = PORT_PINS - 1; i >= 0; i--) begin
      if (pend[i]) code = VEC_W'(2 * (i + 1));
    end
    return code;
  endfunction

  // one-hot pin mask named by a vector code (zero mask for code 0)
  function automatic logic [PORT_PINS-1:0] vec_pin(input logic [VEC_W-1:0] code);
    logic [PORT_PINS-1:0] m;
    m = '0;
    for (int i = 0; i < PORT_PINS; i++) begin
      if (code == VEC_W'(2 * (i + 1))) m[i] = 1'b1;
    end
    return m;
  endfunction
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] raw,
  output logic [W-1:0] level,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);
  logic [W-1:0] stage1_q, stage2_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= '0;
      stage2_q <= '0;
      prev_q   <= '0;
    end else begin
      stage1_q <= raw;
      stage2_q <= stage1_q;
      prev_q   <= stage2_q;
    end
  end

  assign level = stage2_q;
  assign rise  = stage2_q & ~prev_q;
  assign fall  = ~stage2_q & prev_q;
endmodule

// File: rtl/gpio_byte_port.sv
module gpio_byte_port
  import gpio_pair_pkg::*;
#(
  parameter int W = PORT_PINS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_REGS-1:0] wr_sel,
  input  logic [W-1:0]      wdat,
  input  logic [W-1:0]      rise,
  input  logic [W-1:0]      fall,
  input  logic              vec_rd,
  output logic [W-1:0]      dir_q,
  output logic [W-1:0]      out_q,
  output logic [W-1:0]      pen_q,
  output logic [W-1:0]      pup_q,
  output logic [W-1:0]      ien_q,
  output logic [W-1:0]      edge_q,
  output logic [W-1:0]      flag_q,
  output logic [VEC_W-1:0]  vec,
  output logic [W-1:0]      clr,
  output logic [W-1:0]      evt,
  output logic              irq
);
  logic [W-1:0] flag_base;

  assign evt = (~edge_q & rise) | (edge_q & fall);
  assign vec = vec_code(flag_q & ien_q);
  assign clr = vec_rd ? vec_pin(vec) : '0;
  assign irq = |(flag_q & ien_q);
  assign flag_base = wr_sel[RIDX_FLAG] ? wdat : flag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q  <= '0;
      out_q  <= '0;
      pen_q  <= '0;
      pup_q  <= '0;
      ien_q  <= '0;
      edge_q <= '0;
      flag_q <= '0;
    end else begin
      if (wr_sel[RIDX_DIR])    dir_q  <= wdat;
      if (wr_sel[RIDX_OUT])    out_q  <= wdat;
      if (wr_sel[RIDX_PULLEN]) pen_q  <= wdat;
      if (wr_sel[RIDX_PULLUP]) pup_q  <= wdat;
      if (wr_sel[RIDX_IEN])    ien_q  <= wdat;
      if (wr_sel[RIDX_EDGE])   edge_q <= wdat;
      flag_q <= (flag_base & ~clr) | evt;
    end
  end
endmodule

// File: rtl/gpio_pair_port.sv
module gpio_pair_port
  import gpio_pair_pkg::*;
#(
  parameter int PINS  = PORT_PINS,
  parameter int PORTS = NUM_PORTS,
  localparam int TOT  = PINS * PORTS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic              bus_re,
  input  logic [PORTS-1:0]  bus_be,
  input  logic [TOT-1:0]    bus_wdata,
  output logic [TOT-1:0]    bus_rdata,
  input  logic [TOT-1:0]    pad_in,
  output logic [TOT-1:0]    pad_oe,
  output logic [TOT-1:0]    pad_out,
  output logic [TOT-1:0]    pad_pull_en,
  output logic [TOT-1:0]    pad_pull_up,
  output logic [PORTS-1:0]  irq
);
  logic [PORTS-1:0][PINS-1:0]  lvl_p, rise_p, fall_p;
  logic [PORTS-1:0][PINS-1:0]  dir_p, out_p, pen_p, pup_p, ien_p, edge_p, flag_p;
  logic [PORTS-1:0][PINS-1:0]  clr_p, evt_p;
  logic [PORTS-1:0][VEC_W-1:0] vec_p;
  logic [PORTS-1:0]            vec_rd_p;

  // named internal events for the checker
  logic [TOT-1:0]   flag_all, clr_all, evt_all, ien_all;
  logic [VEC_W-1:0] vec_a, vec_b;
  logic             vec_rd_a, vec_rd_b;
  logic [TOT-1:0]   rdata_d;

  genvar p;
  generate
    for (p = 0; p < PORTS; p++) begin : g_port
      logic [NUM_REGS-1:0] wr_sel;
      always_comb begin
        for (int r = 0; r < NUM_REGS; r++) begin
          wr_sel[r] = bus_we && bus_be[p] && (bus_addr == ADDR_W'(r));
        end
      end
      assign vec_rd_p[p] = bus_re && (bus_addr == ADDR_W'(int'(RIDX_VEC_A) + p));

      gpio_in_sync #(.W(PINS)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .raw   (pad_in[p*PINS +: PINS]),
        .level (lvl_p[p]),
        .rise  (rise_p[p]),
        .fall  (fall_p[p])
      );

      gpio_byte_port #(.W(PINS)) u_port (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_sel (wr_sel),
        .wdat   (bus_wdata[p*PINS +: PINS]),
        .rise   (rise_p[p]),
        .fall   (fall_p[p]),
        .vec_rd (vec_rd_p[p]),
        .dir_q  (dir_p[p]),
        .out_q  (out_p[p]),
        .pen_q  (pen_p[p]),
        .pup_q  (pup_p[p]),
        .ien_q  (ien_p[p]),
        .edge_q (edge_p[p]),
        .flag_q (flag_p[p]),
        .vec    (vec_p[p]),
        .clr    (clr_p[p]),
        .evt    (evt_p[p]),
        .irq    (irq[p])
      );
    end
  endgenerate

  assign pad_oe      = dir_p;
  assign pad_out     = out_p;
  assign pad_pull_en = pen_p;
  assign pad_pull_up = pup_p;
  assign flag_all    = flag_p;
  assign clr_all     = clr_p;
  assign evt_all     = evt_p;
  assign ien_all     = ien_p;
  assign vec_a       = vec_p[0];
  assign vec_b       = vec_p[PORTS-1];
  assign vec_rd_a    = vec_rd_p[0];
  assign vec_rd_b    = vec_rd_p[PORTS-1];

  always_comb begin
    rdata_d = '0;
    if (bus_re) begin
      case (bus_addr)
        RIDX_IN:     rdata_d = lvl_p;
        RIDX_OUT:    rdata_d = out_p;
        RIDX_DIR:    rdata_d = dir_p;
        RIDX_PULLEN: rdata_d = pen_p;
        RIDX_PULLUP: rdata_d = pup_p;
        RIDX_IEN:    rdata_d = ien_p;
        RIDX_EDGE:   rdata_d = edge_p;
        RIDX_FLAG:   rdata_d = flag_p;
        RIDX_VEC_A:  rdata_d = TOT'(vec_a);
        RIDX_VEC_B:  rdata_d = TOT'(vec_b);
        default:     rdata_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bus_rdata <= '0;
    else        bus_rdata <= rdata_d;
  end
endmodule

// File: rtl/gpio_pair_port_chk.sv
module gpio_pair_port_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [3:0]  bus_addr,
  input logic        bus_we,
  input logic        bus_re,
  input logic [1:0]  bus_be,
  input logic [15:0] bus_wdata,
  input logic [15:0] bus_rdata,
  input logic [15:0] pad_oe,
  input logic [1:0]  irq,
  input logic [7:0]  vec_a,
  input logic [7:0]  vec_b,
  input logic        vec_rd_a,
  input logic        vec_rd_b,
  input logic [15:0] clr_all,
  input logic [15:0] flag_all,
  input logic [15:0] evt_all
);
  AST_DIR_HALF_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == 4'd2 && bus_be == 2'b11) |=> (pad_oe == $past(bus_wdata))); // R4
  AST_DIR_LANE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == 4'd2 && bus_be == 2'b01) |=> (pad_oe[15:8] == $past(pad_oe[15:8]))); // R4
  AST_VEC_A_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_a != 8'd0) == irq[0]); // R9
  AST_VEC_B_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_b != 8'd0) == irq[1]); // R9
  AST_VEC_A_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_a[0] == 1'b0 && vec_a <= 8'd16)); // R6
  AST_CLR_ONE_PIN: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(clr_all)); // R7
  AST_CLR_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_rd_a && vec_a != 8'd0) |-> ($countones(clr_all[7:0]) == 1)); // R7
  AST_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_all != 16'd0 && (clr_all & evt_all) == 16'd0) |=> ((flag_all & $past(clr_all)) == 16'd0)); // R7
  AST_EVT_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_all != 16'd0) |=> ((flag_all & $past(evt_all)) == $past(evt_all))); // R5
  AST_RDATA_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_re |=> (bus_rdata == 16'd0)); // R11
  AST_NO_PAIR_VEC: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_re && bus_addr >= 4'd10) |=> (bus_rdata == 16'd0)); // R10
  AST_VEC_B_ZERO_NO_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_rd_b && vec_b == 8'd0) |-> (clr_all[15:8] == 8'd0)); // R7
endmodule

bind gpio_pair_port gpio_pair_port_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_addr  (bus_addr),
  .bus_we    (bus_we),
  .bus_re    (bus_re),
  .bus_be    (bus_be),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .pad_oe    (pad_oe),
  .irq       (irq),
  .vec_a     (vec_a),
  .vec_b     (vec_b),
  .vec_rd_a  (vec_rd_a),
  .vec_rd_b  (vec_rd_b),
  .clr_all   (clr_all),
  .flag_all  (flag_all),
  .evt_all   (evt_all)
);

// File: tb/gpio_pair_port_bench.sv
`timescale 1ns/1ps
module gpio_pair_port_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic        bus_re = 1'b0;
  logic [1:0]  bus_be = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [15:0] pad_in = '0;
  logic [15:0] pad_oe, pad_out, pad_pull_en, pad_pull_up;
  logic [1:0]  irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  gpio_pair_port u_gpio_pair_port (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we), .bus_re(bus_re),
    .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_oe(pad_oe), .pad_out(pad_out), .pad_pull_en(pad_pull_en),
    .pad_pull_up(pad_pull_up), .irq(irq)
  );

  // ---------------- behavioural reference model ----------------
  logic [15:0] m_reg [8];
  logic [15:0] m_hist [3];   // pad samples, oldest last
  logic [15:0] m_rdata;

  function automatic int lowest_code(input logic [7:0] pend);
    for (int n = 0; n < 8; n++) if (pend[n]) return 2 * n + 2;
    return 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 8; i++) m_reg[i] = '0;
      for (int i = 0; i < 3; i++) m_hist[i] = '0;
      m_rdata = '0;
    end else begin
      logic [15:0] lvl, old, ev, nflag, pend;
      int ca, cb;
      lvl  = m_hist[1];
      old  = m_hist[2];
      ev   = 16'h0;
      for (int i = 0; i < 16; i++)
        ev[i] = m_reg[6][i] ? (old[i] && !lvl[i]) : (lvl[i] && !old[i]);
      pend = m_reg[7] & m_reg[5];
      ca = lowest_code(pend[7:0]);
      cb = lowest_code(pend[15:8]);
      m_rdata = 16'h0;
      if (bus_re) begin
        if (bus_addr == 0) m_rdata = lvl;
        else if (bus_addr < 8) m_rdata = m_reg[bus_addr[2:0]];
        else if (bus_addr == 8) m_rdata = 16'(ca);
        else if (bus_addr == 9) m_rdata = 16'(cb);
      end
      nflag = m_reg[7];
      if (bus_we && bus_addr >= 1 && bus_addr <= 7) begin
        for (int l = 0; l < 2; l++)
          if (bus_be[l]) begin
            if (bus_addr == 7) nflag[l*8 +: 8] = bus_wdata[l*8 +: 8];
            else m_reg[bus_addr[2:0]][l*8 +: 8] = bus_wdata[l*8 +: 8];
          end
      end
      if (bus_re && bus_addr == 8 && ca != 0) nflag[ca/2 - 1] = 1'b0;
      if (bus_re && bus_addr == 9 && cb != 0) nflag[8 + cb/2 - 1] = 1'b0;
      m_reg[7] = nflag | ev;
      m_hist[2] = m_hist[1];
      m_hist[1] = m_hist[0];
      m_hist[0] = pad_in;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic [15:0] pa, pb;
      logic [1:0] mi;
      pa = m_reg[7] & m_reg[5];
      mi = {|pa[15:8], |pa[7:0]};
      checks++;
      if (pad_oe !== m_reg[2] || pad_out !== m_reg[1] || pad_pull_en !== m_reg[3] ||
          pad_pull_up !== m_reg[4] || irq !== mi || bus_rdata !== m_rdata) begin
        errors++;
        pb = m_rdata;
        $display("FAIL R11 model compare: oe=%h out=%h irq=%b rdata=%h expected oe=%h out=%h irq=%b rdata=%h",
                 pad_oe, pad_out, irq, bus_rdata, m_reg[2], m_reg[1], mi, pb);
      end
    end
  end

  // ---------------- directed stimulus ----------------
  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [1:0] be, input logic [15:0] d);
    bus_addr = a; bus_be = be; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0; bus_be = '0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    bus_addr = a; bus_re = 1'b1;
    @(negedge clk);
    bus_re = 1'b0;
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset dir", pad_oe, 16'h0000);
    check("R9 reset irq", {14'h0, irq}, 16'h0);
    check("R11 reset rdata", bus_rdata, 16'h0);

    wr(4'd2, 2'b11, 16'hA5C3);
    check("R1 R4 half-word dir", pad_oe, 16'hA5C3);
    wr(4'd2, 2'b01, 16'hFF12);
    check("R4 low lane only", pad_oe, 16'hA512);
    wr(4'd2, 2'b10, 16'h7799);
    check("R4 high lane only", pad_oe, 16'h7712);

    wr(4'd1, 2'b11, 16'h3C5A);
    check("R2 out drives pad", pad_out, 16'h3C5A);
    wr(4'd3, 2'b11, 16'h0F0F);
    wr(4'd4, 2'b01, 16'hFF03);
    check("R3 pull enable", pad_pull_en, 16'h0F0F);
    check("R3 pull up lane", pad_pull_up, 16'h0003);

    pad_in = 16'h0081;
    wr(4'd0, 2'b11, 16'hFFFF);
    idle(2);
    rd(4'd0, v);
    check("R2 input readback, write ignored", v, 16'h0081);
    check("R2 output separate from input", pad_out, 16'h3C5A);

    // clear flags raised by the input change
    wr(4'd7, 2'b11, 16'h0000);
    // enable port A pins 3 and 5, rising edges
    wr(4'd5, 2'b01, 16'h0028);
    pad_in = 16'h00AB;             // pins 1,3,5 rise
    idle(4);
    check("R9 port A irq raised", {14'h0, irq}, 16'h0001);
    rd(4'd8, v);
    check("R6 vector names pin 3", v, 16'd8);
    rd(4'd8, v);
    check("R7 read cleared pin 3, pin 5 next", v, 16'd12);
    rd(4'd8, v);
    check("R7 vector empty", v, 16'd0);
    check("R9 irq drops", {14'h0, irq}, 16'h0);
    rd(4'd7, v);
    check("R5 R7 disabled pin flag kept", v, 16'h0002);

    // falling edge on port B pin 2 (global 10)
    pad_in = 16'h04AB;
    idle(4);
    wr(4'd7, 2'b11, 16'h0000);
    wr(4'd6, 2'b10, 16'h0400);
    wr(4'd5, 2'b10, 16'h0400);
    pad_in = 16'h00AB;
    idle(1);
    check("R5 no flag before sync", {14'h0, irq}, 16'h0);
    idle(3);
    check("R9 port B irq", {14'h0, irq}, 16'h0002);
    rd(4'd9, v);
    check("R6 port B vector pin 2", v, 16'd6);
    rd(4'd8, v);
    check("R7 zero vector read", v, 16'd0);

    // direct flag writes
    wr(4'd5, 2'b10, 16'h0100);
    wr(4'd7, 2'b10, 16'h0100);
    check("R8 flag write raises irq", {14'h0, irq}, 16'h0002);
    rd(4'd9, v);
    check("R8 R6 vector pin 0", v, 16'd2);
    wr(4'd7, 2'b11, 16'h0100);
    wr(4'd7, 2'b01, 16'h0000);
    check("R8 R4 lane flag write", {14'h0, irq}, 16'h0002);
    wr(4'd7, 2'b10, 16'h0000);
    check("R8 flags cleared", {14'h0, irq}, 16'h0);

    // unmapped indices
    wr(4'd12, 2'b11, 16'hFFFF);
    rd(4'd12, v);
    check("R10 unmapped reads zero", v, 16'h0);
    rd(4'd10, v);
    check("R10 no pair vector", v, 16'h0);
    rd(4'd2, v);
    check("R10 dir untouched by unmapped write", v, 16'h7712);
    idle(1);
    check("R11 rdata idle zero", bus_rdata, 16'h0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule